// File: doc/BRIEF.md
# 8-bit ALU with status flag generation

This block is a purely combinational byte-wide arithmetic and logic unit. It receives a five-bit operation code, two operand bytes (`opA`, `opB`) and the current status flag byte. It returns a result byte and the updated flag byte within the same cycle. The surrounding core registers both outputs, so the block contains no state.

The operation set covers:

- addition and subtraction, each with or without the incoming carry;
- compare;
- the three bitwise logic operations;
- circular rotates and rotates through carry, in both directions;
- left shift, and arithmetic and logical right shift;
- single-bit test;
- forcing and inverting the carry flag.

The flag byte layout is fixed. One bit of it reports either signed overflow or result parity, depending on the class of operation. Operations that produce no new value return `opA` unchanged, so the accumulator path can always write the result port back.

Top module: `alu8_flags`

## Requirements
- R1: The flag byte places sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract at bit 1 and carry at bit 0. Bits 5 and 3 of `flagsOut` always equal bits 5 and 3 of `flagsIn`.
- R2: The opcode values are as follows:
  - 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare;
  - 5 AND, 6 OR, 7 XOR;
  - 8 rotate left circular, 9 rotate right circular, 10 rotate left through carry, 11 rotate right through carry;
  - 12 shift left, 13 arithmetic shift right, 14 logical shift right;
  - 15 bit test, 16 set carry, 17 complement carry.
- R3: Add and add-with-carry return (A + B + cin) mod 256. Here cin is incoming C for opcode 1 and 0 for opcode 0. C is the carry out of bit 7, H is the carry from bit 3 into bit 4, and N is 0.
- R4: Subtract and subtract-with-borrow return (A − B − cin) mod 256. Here cin is incoming C for opcode 3 and 0 for opcode 2. C is 1 on a borrow, H is 1 on a borrow from bit 4, and N is 1.
- R5: For opcodes 0 to 4, P/V is 1 exactly when the true signed result lies outside −128..+127.
- R6: Compare sets every flag as subtract does, so Z is 1 exactly when A equals B. The result port returns A unchanged.
- R7: AND, OR and XOR clear C and N, set H to 1 for AND and to 0 otherwise, and set P/V to 1 when the result has an even number of one bits.
- R8: The rotates and shifts act on A:
  - A left operation fills bit 0 with, in order of opcodes 8, 10 and 12: old bit 7, incoming C, or 0. Its C output takes old bit 7.
  - A right operation fills bit 7 with, in order of opcodes 9, 11, 13 and 14: old bit 0, incoming C, old bit 7, or 0. Its C output takes old bit 0.
  - H and N are 0, and P/V is the even parity of the result.
- R9: For opcodes 0 to 14, S equals bit 7 of the computed value and Z is 1 when that value is zero. For compare, the computed value is the difference.
- R10: Bit test returns A and sets Z to the inverse of A[B[2:0]]. It sets H to 1 and N to 0, and keeps S, P/V and C from the incoming flags.
- R11: Set carry forces C to 1 and complement carry inverts C. Both clear N, keep all other flags, and return A.
- R12: Opcodes 18 to 31 return A and pass `flagsIn` through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 5 | Operation select (encoding in R2) |
| opA | input | 8 | First operand; source of rotates, shifts and bit test |
| opB | input | 8 | Second operand; bit index in B[2:0] for bit test |
| flagsIn | input | 8 | Incoming status flag byte |
| result | output | 8 | Result byte |
| flagsOut | output | 8 | Updated status flag byte |

## Verification
Immediate assertions in the datapath and top guard several properties on every evaluation:

- the cleared carry after logic operations;
- N after a subtract;
- the two-operand sign rule for overflow;
- even parity for logic, rotate and shift results;
- the equality rule behind compare's Z;
- the sign bit;
- the pass-through of the spare flag bits and of unassigned opcodes.

Only the bench's scenarios can show that the arithmetic values, the borrow and half-borrow cases, the fill bit of each rotate and shift, the bit index of bit test, and carry chaining with an incoming C agree with the requirements. It does this through directed corner vectors and a long pseudo-random sweep over all 32 opcodes, against a behavioural integer model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int OP_W   = 5;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int NIB_W  = DATA_W / 2;

  // Flag bit positions (R1)
  localparam int FLG_S  = 7;
  localparam int FLG_Z  = 6;
  localparam int FLG_H  = 4;
  localparam int FLG_PV = 2;
  localparam int FLG_N  = 1;
  localparam int FLG_C  = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_RLC = 5'd8,  OP_RRC = 5'd9,  OP_RL  = 5'd10, OP_RR  = 5'd11,
    OP_SLA = 5'd12, OP_SRA = 5'd13, OP_SRL = 5'd14, OP_BIT = 5'd15,
    OP_SCF = 5'd16, OP_CCF = 5'd17
  } aluOp_e;

  typedef enum logic [1:0] { LOG_AND = 2'd0, LOG_OR = 2'd1, LOG_XOR = 2'd2 } logicSel_e;
  typedef enum logic [1:0] { FILL_ZERO = 2'd0, FILL_CIRC = 2'd1, FILL_CARRY = 2'd2, FILL_SIGN = 2'd3 } fillSel_e;

  typedef struct packed {
    logic      arith;
    logic      sub;
    logic      useCarry;
    logic      keepA;
    logic      logicEn;
    logicSel_e logicSel;
    logic      shiftEn;
    logic      shLeft;
    fillSel_e  fill;
    logic      bitTest;
    logic      carrySet;
    logic      carryFlip;
  } aluStrobes_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStrobes_t     strb
);

  always_comb begin
    strb = '0;
    case (aluOp_e'(opCode))
      OP_ADD: strb.arith = 1'b1;
      OP_ADC: begin strb.arith = 1'b1; strb.useCarry = 1'b1; end
      OP_SUB: begin strb.arith = 1'b1; strb.sub = 1'b1; end
      OP_SBC: begin strb.arith = 1'b1; strb.sub = 1'b1; strb.useCarry = 1'b1; end
      OP_CMP: begin strb.arith = 1'b1; strb.sub = 1'b1; strb.keepA = 1'b1; end
      OP_AND: begin strb.logicEn = 1'b1; strb.logicSel = LOG_AND; end
      OP_OR:  begin strb.logicEn = 1'b1; strb.logicSel = LOG_OR;  end
      OP_XOR: begin strb.logicEn = 1'b1; strb.logicSel = LOG_XOR; end
      OP_RLC: begin strb.shiftEn = 1'b1; strb.shLeft = 1'b1; strb.fill = FILL_CIRC;  end
      OP_RRC: begin strb.shiftEn = 1'b1; strb.fill = FILL_CIRC;  end
      OP_RL:  begin strb.shiftEn = 1'b1; strb.shLeft = 1'b1; strb.fill = FILL_CARRY; end
      OP_RR:  begin strb.shiftEn = 1'b1; strb.fill = FILL_CARRY; end
      OP_SLA: begin strb.shiftEn = 1'b1; strb.shLeft = 1'b1; strb.fill = FILL_ZERO;  end
      OP_SRA: begin strb.shiftEn = 1'b1; strb.fill = FILL_SIGN;  end
      OP_SRL: begin strb.shiftEn = 1'b1; strb.fill = FILL_ZERO;  end
      OP_BIT: strb.bitTest   = 1'b1;
      OP_SCF: strb.carrySet  = 1'b1;
      OP_CCF: strb.carryFlip = 1'b1;
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
(
  input  aluStrobes_t       strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flagsOut
);

  localparam int MSB = DATA_W - 1;

  logic              carryIn, cinRaw, cinEff;
  logic [DATA_W-1:0] bEff;
  logic [NIB_W:0]    lowSum;
  logic [MSB:0]      sevenSum;
  logic [DATA_W:0]   fullSum;
  logic [DATA_W-1:0] arithRes, logicRes, shiftRes, value;
  logic              arithC, arithH, arithV, fillBit, shiftC, testedBit;

  // Adder: subtraction runs as A + ~B + ~borrowIn
  always_comb begin
    carryIn  = flagsIn[FLG_C];
    cinRaw   = strb.useCarry & carryIn;
    cinEff   = strb.sub ? ~cinRaw : cinRaw;
    bEff     = strb.sub ? ~opB : opB;
    lowSum   = {1'b0, opA[NIB_W-1:0]} + {1'b0, bEff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cinEff};
    sevenSum = {1'b0, opA[MSB-1:0]} + {1'b0, bEff[MSB-1:0]} + {{MSB{1'b0}}, cinEff};
    fullSum  = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, cinEff};
    arithRes = fullSum[DATA_W-1:0];
    arithC   = fullSum[DATA_W] ^ strb.sub;
    arithH   = lowSum[NIB_W] ^ strb.sub;
    arithV   = sevenSum[MSB] ^ fullSum[DATA_W];
  end

  // Logic unit
  always_comb begin
    case (strb.logicSel)
      LOG_AND: logicRes = opA & opB;
      LOG_OR:  logicRes = opA | opB;
      default: logicRes = opA ^ opB;
    endcase
  end

  // Rotate / shift unit
  always_comb begin
    case (strb.fill)
      FILL_CIRC:  fillBit = strb.shLeft ? opA[MSB] : opA[0];
      FILL_CARRY: fillBit = carryIn;
      FILL_SIGN:  fillBit = opA[MSB];
      default:    fillBit = 1'b0;
    endcase
    shiftRes = strb.shLeft ? {opA[MSB-1:0], fillBit} : {fillBit, opA[MSB:1]};
    shiftC   = strb.shLeft ? opA[MSB] : opA[0];
  end

  assign testedBit = opA[opB[IDX_W-1:0]];

  // Result and flag assembly; untouched flag bits keep flagsIn
  always_comb begin
    result   = opA;
    flagsOut = flagsIn;
    value    = opA;
    if (strb.arith) begin
      value            = arithRes;
      result           = strb.keepA ? opA : arithRes;
      flagsOut[FLG_H]  = arithH;
      flagsOut[FLG_PV] = arithV;
      flagsOut[FLG_N]  = strb.sub;
      flagsOut[FLG_C]  = arithC;
    end else if (strb.logicEn) begin
      value            = logicRes;
      result           = logicRes;
      flagsOut[FLG_H]  = (strb.logicSel == LOG_AND);
      flagsOut[FLG_PV] = ~^logicRes;
      flagsOut[FLG_N]  = 1'b0;
      flagsOut[FLG_C]  = 1'b0;
    end else if (strb.shiftEn) begin
      value            = shiftRes;
      result           = shiftRes;
      flagsOut[FLG_H]  = 1'b0;
      flagsOut[FLG_PV] = ~^shiftRes;
      flagsOut[FLG_N]  = 1'b0;
      flagsOut[FLG_C]  = shiftC;
    end else if (strb.bitTest) begin
      flagsOut[FLG_Z]  = ~testedBit;
      flagsOut[FLG_H]  = 1'b1;
      flagsOut[FLG_N]  = 1'b0;
    end else if (strb.carrySet || strb.carryFlip) begin
      flagsOut[FLG_N]  = 1'b0;
      flagsOut[FLG_C]  = strb.carrySet ? 1'b1 : ~carryIn;
    end
    if (strb.arith || strb.logicEn || strb.shiftEn) begin
      flagsOut[FLG_S] = value[MSB];
      flagsOut[FLG_Z] = (value == '0);
    end
  end

  always_comb begin
    // R7
    logic_carry_chk: assert (!strb.logicEn || (flagsOut[FLG_C] == 1'b0 && flagsOut[FLG_N] == 1'b0))
      else $error("logic op left C or N set");
    // R4
    sub_n_chk: assert (!(strb.arith && strb.sub) || flagsOut[FLG_N])
      else $error("subtract did not set N");
    // R5
    no_overflow_chk: assert (!strb.arith ||
      (flagsOut[FLG_PV] == ((opA[MSB] == bEff[MSB]) && (arithRes[MSB] != opA[MSB]))))
      else $error("overflow flag disagrees with sign rule");
    // R8
    parity_chk: assert (!(strb.logicEn || strb.shiftEn) ||
      (flagsOut[FLG_PV] == ($countones(result) % 2 == 0)))
      else $error("parity flag wrong");
    // R6
    cmp_zero_chk: assert (!(strb.arith && strb.keepA) ||
      (flagsOut[FLG_Z] == (opA == opB) && result == opA))
      else $error("compare zero flag or result wrong");
    // R9
    sign_chk: assert (!(strb.logicEn || strb.shiftEn) || flagsOut[FLG_S] == result[MSB])
      else $error("sign flag differs from result msb");
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flagsOut
);

  localparam int NUM_OPS = 18;

  aluStrobes_t strb;

  alu8_ctrl u_ctrl (
    .opCode (opCode),
    .strb   (strb)
  );

  alu8_dp u_dp (
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );

  always_comb begin
    // R1
    spare_bits_chk: assert (flagsOut[5] == flagsIn[5] && flagsOut[3] == flagsIn[3])
      else $error("spare flag bits altered");
    // R12
    unused_op_chk: assert (int'(opCode) < NUM_OPS || (result == opA && flagsOut == flagsIn))
      else $error("unassigned opcode changed state");
  end

endmodule

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] opA = '0, opB = '0, flagsIn = '0;
  logic [7:0] result, flagsOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  alu8_flags u_dut (
    .opCode(opCode), .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut)
  );

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // Behavioural model: returns {result, flags}
  function automatic logic [15:0] refAlu(int op, int a, int b, logic [7:0] f);
    int r, full, half, s, cin, co, idx;
    logic [7:0] nf, ra;
    logic sub;
    nf = f; r = a; cin = int'(f[0]);
    ra = 8'(a);
    if (op <= 4) begin
      sub = (op >= 2);
      if (op == 0 || op == 2 || op == 4) cin = 0;
      if (!sub) begin
        full = a + b + cin; half = (a % 16) + (b % 16) + cin; s = sgn(a) + sgn(b) + cin;
        nf[0] = (full > 255); nf[4] = (half > 15);
      end else begin
        full = a - b - cin; half = (a % 16) - (b % 16) - cin; s = sgn(a) - sgn(b) - cin;
        nf[0] = (full < 0); nf[4] = (half < 0);
      end
      r = (full + 512) % 256;
      nf[2] = (s > 127) || (s < -128);
      nf[1] = sub;
      nf[7] = (r >= 128); nf[6] = (r == 0);
      if (op == 4) r = a;
    end else if (op <= 7) begin
      if (op == 5) r = a & b; else if (op == 6) r = a | b; else r = a ^ b;
      nf[0] = 0; nf[1] = 0; nf[4] = (op == 5);
      nf[2] = ($countones(8'(r)) % 2 == 0);
      nf[7] = (r >= 128); nf[6] = (r == 0);
    end else if (op <= 14) begin
      case (op)
        8:  begin co = a / 128; r = (a * 2) % 256 + co; end
        9:  begin co = a % 2;   r = a / 2 + co * 128; end
        10: begin co = a / 128; r = (a * 2) % 256 + cin; end
        11: begin co = a % 2;   r = a / 2 + cin * 128; end
        12: begin co = a / 128; r = (a * 2) % 256; end
        13: begin co = a % 2;   r = a / 2 + (a / 128) * 128; end
        default: begin co = a % 2; r = a / 2; end
      endcase
      nf[0] = (co != 0); nf[1] = 0; nf[4] = 0;
      nf[2] = ($countones(8'(r)) % 2 == 0);
      nf[7] = (r >= 128); nf[6] = (r == 0);
    end else if (op == 15) begin
      idx = b % 8;
      nf[6] = ~ra[idx]; nf[4] = 1; nf[1] = 0;
    end else if (op == 16) begin
      nf[0] = 1; nf[1] = 0;
    end else if (op == 17) begin
      nf[0] = ~f[0]; nf[1] = 0;
    end
    return {8'(r), nf};
  endfunction

  function automatic string tagFor(int op);
    if (op <= 1)  return "R3";
    if (op <= 3)  return "R4";
    if (op == 4)  return "R6";
    if (op <= 7)  return "R7";
    if (op <= 14) return "R8";
    if (op == 15) return "R10";
    if (op <= 17) return "R11";
    return "R12";
  endfunction

  task automatic applyChk(int op, int a, int b, logic [7:0] f, string tag);
    logic [15:0] exp;
    @(negedge clk);
    opCode = 5'(op); opA = 8'(a); opB = 8'(b); flagsIn = f;
    @(posedge clk);
    #2;
    exp = refAlu(op, a, b, f);
    nChecks++;
    if (result !== exp[15:8] || flagsOut !== exp[7:0]) begin
      nFail++;
      $display("FAIL %s op=%0d a=%h b=%h f=%h : got res=%h flags=%h exp res=%h flags=%h",
               tag, op, a, b, f, result, flagsOut, exp[15:8], exp[7:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: all-zero inputs is ADD 0+0 -> result 0, Z only (R9)
    applyChk(0, 0, 0, 8'h00, "R9");
    // R3 add cases
    applyChk(0, 8'h78, 8'h69, 8'h00, "R5");
    applyChk(0, 8'hFF, 8'h01, 8'h00, "R3");
    applyChk(1, 8'h0F, 8'h00, 8'h01, "R3");
    applyChk(1, 8'h7F, 8'h00, 8'h01, "R5");
    // R4 subtract cases
    applyChk(2, 8'h7F, 8'hC0, 8'h00, "R5");
    applyChk(2, 8'h10, 8'h01, 8'h00, "R4");
    applyChk(3, 8'h00, 8'h00, 8'h01, "R4");
    applyChk(3, 8'h80, 8'h00, 8'h01, "R5");
    // R6 compare
    applyChk(4, 8'h42, 8'h42, 8'h00, "R6");
    applyChk(4, 8'h10, 8'h20, 8'h01, "R6");
    // R7 logic
    applyChk(5, 8'hF0, 8'h3C, 8'h01, "R7");
    applyChk(6, 8'h00, 8'h00, 8'h01, "R7");
    applyChk(7, 8'hAA, 8'h55, 8'h01, "R7");
    // R8 rotates and shifts with distinctive patterns
    for (int op = 8; op <= 14; op++) begin
      applyChk(op, 8'h81, 0, 8'h01, "R8");
      applyChk(op, 8'h42, 0, 8'h00, "R8");
    end
    // R10 bit test at every index
    for (int i = 0; i < 8; i++) applyChk(15, 8'hA5, i, 8'hA5, "R10");
    // R11 carry control
    applyChk(16, 8'h33, 0, 8'hC6, "R11");
    applyChk(17, 8'h33, 0, 8'hC7, "R11");
    applyChk(17, 8'h33, 0, 8'hC4, "R11");
    // R12 unassigned opcodes
    applyChk(18, 8'h12, 8'h34, 8'h5A, "R12");
    applyChk(31, 8'hFE, 8'h01, 8'hFF, "R12");
    // R1 spare bits pass through across several classes
    applyChk(0, 8'h01, 8'h02, 8'h28, "R1");
    applyChk(7, 8'h01, 8'h02, 8'h28, "R1");
    applyChk(11, 8'h01, 8'h02, 8'h28, "R1");
    // R2 opcode decode: pseudo-random sweep across all opcodes
    for (int n = 0; n < 4000; n++) begin
      int op, a, b, f;
      op = int'($urandom % 32); a = int'($urandom % 256);
      b  = int'($urandom % 256); f = int'($urandom % 256);
      applyChk(op, a, b, 8'(f), (op < 18) ? tagFor(op) : "R2");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule